// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Checker

This block is a passive observer for the pins of an asynchronous static RAM with four byte lanes. A fast clock samples every pin: the address, the data bus value, a flag that says whether the controller is driving the bus, the active-low select, the active-high chip enable, the active-low write strobe, the active-low output enable and four active-low lane enables. The observer never drives the bus. It decodes each sample into write, read or deselect. It measures pulse widths, setup intervals and recovery gaps in sample ticks, and reports each broken rule on its own sticky flag.

A write takes place only while all of its strobes overlap. Any one of the strobes can open or close the write window, and the block times that overlap rather than one pin. When a window closes with every rule met, the write counter advances once. When a read window holds the same address and lanes for the access time, the read counter advances once. Bus contention is reported in two cases: the controller drives while the RAM drives, or the controller drives too soon after the RAM has released the bus.

Top module: `sram_bus_monitor`

## Requirements
- R1: A sample is an effective write when `wr_n`=0, `sel_n`=0, `chip_en`=1 and at least one bit of `lane_en_n` is 0. Any of these pins may open or close the write window. With every lane enable at 1, or with `chip_en`=0, no write exists and nothing is counted.
- R2: An effective write shorter than `T_WP` samples sets `viol[0]`.
- R3: At the last sample of a write, the bus must have been driven with one unchanged value for at least `T_DS` consecutive samples. Otherwise `viol[1]` is set.
- R4: An address change between two consecutive write samples sets `viol[2]`.
- R5: After an earlier write, a new write that begins fewer than `T_REC` non-write samples after the previous one ended sets `viol[3]`.
- R6: `wr_count` rises by exactly one when a write window closes, and only when that write broke none of R2 to R5.
- R7: A read sample is `sel_n`=0, `chip_en`=1, `wr_n`=1, `out_en_n`=0 with at least one lane enable at 0. `rd_count` rises by one once per read window that reaches `T_ACC` consecutive read samples with unchanged address and lane enables. A change of either restarts the window.
- R8: The controller driving the bus on a read sample sets `viol[4]`.
- R9: While selected (`sel_n`=0, `chip_en`=1), the controller driving the bus within `T_TURN` samples after the last read sample sets `viol[4]`. The first sample after the read counts as 1.
- R10: In deselect (`sel_n`=1 or `chip_en`=0), driving the bus never sets `viol[4]`.
- R11: Reset clears the flags and both counters. A flag stays set until `clr` is high at a clock edge. A sample's effect appears at the outputs after the second rising edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all violation flags |
| bus_addr | input | AW | Address pins |
| bus_data | input | 8*LANES | Data bus value |
| bus_drive | input | 1 | Controller is driving the data bus |
| sel_n | input | 1 | Active-low select |
| chip_en | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| lane_en_n | input | LANES | Active-low byte lane enables |
| viol | output | 5 | Sticky flags: 0 pulse, 1 data setup, 2 address, 3 recovery, 4 contention |
| wr_count | output | CW | Count of clean writes |
| rd_count | output | CW | Count of completed reads |

## Verification
A read can complete its access time on the same sample on which the controller starts driving the bus. The bench provokes this by holding a read for exactly `T_ACC` samples and raising `bus_drive` only on the last one. The result is correct only if `rd_count` advances and `viol[4]` is set, because the two functions must not suppress each other. The write rules can also fire together. A one-sample write breaks both the width rule and the setup rule, and both flags must be set while the counter stays put.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  localparam int F_PULSE = 0;
  localparam int F_SETUP = 1;
  localparam int F_ADDR  = 2;
  localparam int F_RECOV = 3;
  localparam int F_CONT  = 4;
  localparam int NFLAGS  = 5;

  typedef struct packed {
    logic sel_n;
    logic chip_en;
    logic wr_n;
    logic oe_n;
    logic drv;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, chip_en: 1'b0, wr_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
endpackage

// File: rtl/sram_mon_sample.sv
module sram_mon_sample
  import sram_mon_pkg::*;
#(
  parameter int AW    = 19,
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    data_in,
  input  ctl_t             ctl_in,
  input  logic [LANES-1:0] lane_in,
  output logic [AW-1:0]    addr_c,
  output logic [AW-1:0]    addr_p,
  output logic [DW-1:0]    data_c,
  output logic [DW-1:0]    data_p,
  output logic             drv_c,
  output logic             drv_p,
  output logic [LANES-1:0] lane_c,
  output logic [LANES-1:0] lane_p,
  output logic             we_c,
  output logic             we_p,
  output logic             rd_c,
  output logic             rd_p,
  output logic             sel_c
);
  ctl_t ctl_c, ctl_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_c  <= CTL_IDLE;
      ctl_p  <= CTL_IDLE;
      lane_c <= '1;
      lane_p <= '1;
      addr_c <= '0;
      addr_p <= '0;
      data_c <= '0;
      data_p <= '0;
    end else begin
      ctl_c  <= ctl_in;
      ctl_p  <= ctl_c;
      lane_c <= lane_in;
      lane_p <= lane_c;
      addr_c <= addr_in;
      addr_p <= addr_c;
      data_c <= data_in;
      data_p <= data_c;
    end
  end

  assign sel_c = ~ctl_c.sel_n & ctl_c.chip_en;
  assign we_c  = sel_c & ~ctl_c.wr_n & ~(&lane_c);
  assign we_p  = ~ctl_p.sel_n & ctl_p.chip_en & ~ctl_p.wr_n & ~(&lane_p);
  assign rd_c  = sel_c & ctl_c.wr_n & ~ctl_c.oe_n & ~(&lane_c);
  assign rd_p  = ~ctl_p.sel_n & ctl_p.chip_en & ctl_p.wr_n & ~ctl_p.oe_n & ~(&lane_p);
  assign drv_c = ctl_c.drv;
  assign drv_p = ctl_p.drv;
endmodule

// File: rtl/sram_mon_wr.sv
module sram_mon_wr #(
  parameter int AW    = 19,
  parameter int DW    = 32,
  parameter int T_WP  = 3,
  parameter int T_DS  = 2,
  parameter int T_REC = 2,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic          we_p,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] addr_p,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] data_p,
  input  logic          drv,
  input  logic          drv_p,
  output logic [3:0]    flags,
  output logic [CW-1:0] wr_count
);
  localparam int MAX_A = (T_WP > T_DS) ? T_WP : T_DS;
  localparam int MAXT  = ((MAX_A > T_REC) ? MAX_A : T_REC) + 1;
  localparam int TW    = $clog2(MAXT + 1);
  localparam logic [TW-1:0] SAT   = TW'(MAXT);
  localparam logic [TW-1:0] WP_C  = TW'(T_WP);
  localparam logic [TW-1:0] DS_C  = TW'(T_DS);
  localparam logic [TW-1:0] REC_C = TW'(T_REC);

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] x);
    return (x == SAT) ? x : x + 1'b1;
  endfunction

  logic [TW-1:0] wcnt, dcnt, gap;
  logic seen, bad;

  logic rise, fall, addr_move, pw_short, ds_short, rc_short, ok_end;
  assign rise      = we & ~we_p;
  assign fall      = ~we & we_p;
  assign addr_move = we & we_p & (addr != addr_p);
  assign pw_short  = fall & (wcnt < WP_C);
  assign ds_short  = fall & (dcnt < DS_C);
  assign rc_short  = rise & seen & (gap < REC_C);
  assign ok_end    = fall & ~bad & ~pw_short & ~ds_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt     <= '0;
      dcnt     <= '0;
      gap      <= SAT;
      seen     <= 1'b0;
      bad      <= 1'b0;
      flags    <= '0;
      wr_count <= '0;
    end else begin
      wcnt <= we ? (rise ? TW'(1) : bump(wcnt)) : '0;
      dcnt <= drv ? ((drv_p && data == data_p) ? bump(dcnt) : TW'(1)) : '0;
      gap  <= we ? '0 : (fall ? TW'(1) : bump(gap));
      if (fall) seen <= 1'b1;
      bad  <= rise ? rc_short : (bad | addr_move);
      if (ok_end) wr_count <= wr_count + 1'b1;
      if (clr) flags <= '0;
      else     flags <= flags | {rc_short, addr_move, ds_short, pw_short};
    end
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags) & ~flags)) |-> $past(clr));
  assert_pulse_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(fall));
  assert_addr_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[2]) |-> $past(we && we_p));
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_count != $past(wr_count)) |-> ($past(fall) && wr_count == $past(wr_count) + 1'b1));
endmodule

// File: rtl/sram_mon_bus.sv
module sram_mon_bus #(
  parameter int AW     = 19,
  parameter int LANES  = 4,
  parameter int T_ACC  = 6,
  parameter int T_TURN = 2,
  parameter int CW     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rd,
  input  logic             rd_p,
  input  logic             sel,
  input  logic             drv,
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    addr_p,
  input  logic [LANES-1:0] lane,
  input  logic [LANES-1:0] lane_p,
  output logic             cont,
  output logic [CW-1:0]    rd_count
);
  localparam int RW = $clog2(T_ACC + 1);
  localparam int SW = $clog2(T_TURN + 2);
  localparam logic [RW-1:0] ACC_C  = RW'(T_ACC);
  localparam logic [RW-1:0] ACC_M1 = RW'(T_ACC - 1);
  localparam logic [SW-1:0] S_SAT  = SW'(T_TURN + 1);
  localparam logic [SW-1:0] TURN_C = SW'(T_TURN);
  localparam bit ACC_ONE = (T_ACC == 1);

  logic [RW-1:0] racc;
  logic [SW-1:0] since, since_now;
  logic cont_rd, rd_hit, clash;

  assign cont_rd   = rd_p & (addr == addr_p) & (lane == lane_p);
  assign rd_hit    = rd & (cont_rd ? (racc == ACC_M1) : ACC_ONE);
  assign since_now = rd ? '0 : (rd_p ? SW'(1) : ((since == S_SAT) ? since : since + 1'b1));
  assign clash     = sel & drv & (rd | (since_now <= TURN_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      racc     <= '0;
      since    <= S_SAT;
      cont     <= 1'b0;
      rd_count <= '0;
    end else begin
      racc  <= rd ? (cont_rd ? ((racc == ACC_C) ? racc : racc + 1'b1) : RW'(1)) : '0;
      since <= since_now;
      if (rd_hit) rd_count <= rd_count + 1'b1;
      if (clr) cont <= 1'b0;
      else     cont <= cont | clash;
    end
  end

  assert_cont_selected_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cont) |-> $past(sel && drv));
  assert_cont_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(cont) |-> $past(clr));
  assert_read_count_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_count != $past(rd_count)) |-> ($past(rd) && rd_count == $past(rd_count) + 1'b1));
endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
  import sram_mon_pkg::*;
#(
  parameter int AW     = 19,
  parameter int LANES  = 4,
  parameter int T_WP   = 3,
  parameter int T_DS   = 2,
  parameter int T_REC  = 2,
  parameter int T_ACC  = 6,
  parameter int T_TURN = 2,
  parameter int CW     = 16,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_drive,
  input  logic              sel_n,
  input  logic              chip_en,
  input  logic              wr_n,
  input  logic              out_en_n,
  input  logic [LANES-1:0]  lane_en_n,
  output logic [NFLAGS-1:0] viol,
  output logic [CW-1:0]     wr_count,
  output logic [CW-1:0]     rd_count
);
  ctl_t ctl_in;
  assign ctl_in = '{sel_n: sel_n, chip_en: chip_en, wr_n: wr_n, oe_n: out_en_n, drv: bus_drive};

  logic [AW-1:0]    addr_c, addr_p;
  logic [DW-1:0]    data_c, data_p;
  logic [LANES-1:0] lane_c, lane_p;
  logic drv_c, drv_p, we_c, we_p, rd_c, rd_p, sel_c;
  logic [3:0] wflags;
  logic cont;

  sram_mon_sample #(.AW(AW), .LANES(LANES)) u_sample (
    .clk(clk), .rst(rst), .addr_in(bus_addr), .data_in(bus_data),
    .ctl_in(ctl_in), .lane_in(lane_en_n),
    .addr_c(addr_c), .addr_p(addr_p), .data_c(data_c), .data_p(data_p),
    .drv_c(drv_c), .drv_p(drv_p), .lane_c(lane_c), .lane_p(lane_p),
    .we_c(we_c), .we_p(we_p), .rd_c(rd_c), .rd_p(rd_p), .sel_c(sel_c)
  );

  sram_mon_wr #(.AW(AW), .DW(DW), .T_WP(T_WP), .T_DS(T_DS), .T_REC(T_REC), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .clr(clr), .we(we_c), .we_p(we_p),
    .addr(addr_c), .addr_p(addr_p), .data(data_c), .data_p(data_p),
    .drv(drv_c), .drv_p(drv_p), .flags(wflags), .wr_count(wr_count)
  );

  sram_mon_bus #(.AW(AW), .LANES(LANES), .T_ACC(T_ACC), .T_TURN(T_TURN), .CW(CW)) u_bus (
    .clk(clk), .rst(rst), .clr(clr), .rd(rd_c), .rd_p(rd_p), .sel(sel_c),
    .drv(drv_c), .addr(addr_c), .addr_p(addr_p), .lane(lane_c), .lane_p(lane_p),
    .cont(cont), .rd_count(rd_count)
  );

  assign viol[F_PULSE] = wflags[0];
  assign viol[F_SETUP] = wflags[1];
  assign viol[F_ADDR]  = wflags[2];
  assign viol[F_RECOV] = wflags[3];
  assign viol[F_CONT]  = cont;
endmodule

// File: tb/tb_sram_bus_monitor.sv
module tb_sram_bus_monitor;
  localparam int AW = 19;
  localparam int LANES = 4;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int T_WP = 3, T_DS = 2, T_REC = 2, T_ACC = 6, T_TURN = 2;

  logic clk = 1'b0;
  logic rst, clr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic bus_drive, sel_n, chip_en, wr_n, out_en_n;
  logic [LANES-1:0] lane_en_n;
  logic [4:0] viol;
  logic [CW-1:0] wr_count, rd_count;

  int total = 0;
  int bad = 0;
  int exp_wr = 0;
  int exp_rd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_bus_monitor #(.AW(AW), .LANES(LANES), .T_WP(T_WP), .T_DS(T_DS), .T_REC(T_REC),
                     .T_ACC(T_ACC), .T_TURN(T_TURN), .CW(CW)) dut (
    .clk(clk), .rst(rst), .clr(clr), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_drive(bus_drive), .sel_n(sel_n), .chip_en(chip_en), .wr_n(wr_n),
    .out_en_n(out_en_n), .lane_en_n(lane_en_n), .viol(viol),
    .wr_count(wr_count), .rd_count(rd_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    sel_n = 1'b1; chip_en = 1'b1; wr_n = 1'b1; out_en_n = 1'b1;
    lane_en_n = '1; bus_drive = 1'b0;
    tick(n);
  endtask

  task automatic clear_flags();
    idle(4);
    clr = 1'b1; tick(1); clr = 1'b0;
    idle(8);
  endtask

  task automatic write_on(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_n = 1'b0; chip_en = 1'b1; wr_n = 1'b0; out_en_n = 1'b1;
    lane_en_n = '0; bus_drive = 1'b1; bus_addr = a; bus_data = d;
  endtask

  task automatic read_on(input logic [AW-1:0] a);
    sel_n = 1'b0; chip_en = 1'b1; wr_n = 1'b1; out_en_n = 1'b0;
    lane_en_n = '0; bus_drive = 1'b0; bus_addr = a;
  endtask

  task automatic check_counts(input string tag);
    chk({tag, " wr_count"}, 32'(wr_count), 32'(exp_wr));
    chk({tag, " rd_count"}, 32'(rd_count), 32'(exp_rd));
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; bus_addr = '0; bus_data = '0;
    idle(5);
    rst = 1'b0;
    idle(2);
    chk("R11 reset flags", 32'(viol), 0);
    check_counts("R11 reset");

    // R2/R3/R6: write width sweep with data held from the first write sample
    for (int w = 1; w <= 6; w++) begin
      clear_flags();
      write_on(19'h100 + 19'(w), 32'hA5A5_0000 + 32'(w));
      tick(w);
      idle(4);
      if (w >= T_WP && w >= T_DS) exp_wr++;
      chk($sformatf("R2 R3 width=%0d flags", w), 32'(viol),
          32'({(w < T_DS), (w < T_WP)}));
      check_counts($sformatf("R6 width=%0d", w));
    end

    // R3: data settles d samples before end of a 5-sample write
    for (int d = 1; d <= 5; d++) begin
      clear_flags();
      write_on(19'h200, 32'h1111_1111);
      tick(5 - d);
      bus_data = 32'h2222_2222;
      tick(d);
      idle(4);
      if (d >= T_DS) exp_wr++;
      chk($sformatf("R3 setup=%0d flags", d), 32'(viol), 32'((d < T_DS) ? 2 : 0));
      check_counts($sformatf("R3 setup=%0d", d));
    end

    // R5: recovery gap sweep between two writes
    for (int g = 1; g <= 4; g++) begin
      clear_flags();
      write_on(19'h300, 32'h3);
      tick(4);
      wr_n = 1'b1; bus_drive = 1'b0;
      tick(g);
      write_on(19'h301, 32'h4);
      tick(4);
      idle(4);
      exp_wr += (g >= T_REC) ? 2 : 1;
      chk($sformatf("R5 gap=%0d flags", g), 32'(viol), 32'((g < T_REC) ? 8 : 0));
      check_counts($sformatf("R5 gap=%0d", g));
    end

    // R4: address moves inside a write
    clear_flags();
    write_on(19'h400, 32'h5);
    tick(2);
    bus_addr = 19'h401;
    tick(2);
    idle(4);
    chk("R4 addr move flags", 32'(viol), 32'h4);
    check_counts("R4 no count");

    // R1: write opened by select, closed by lane enables
    clear_flags();
    write_on(19'h500, 32'h6);
    sel_n = 1'b1;
    tick(2);
    sel_n = 1'b0;
    tick(4);
    lane_en_n = '1;
    tick(1);
    idle(4);
    exp_wr++;
    chk("R1 select-open lane-close flags", 32'(viol), 0);
    check_counts("R1 select-open lane-close");

    // R1: write closed by chip enable, single lane used
    write_on(19'h501, 32'h7);
    lane_en_n = 4'b1011;
    tick(4);
    chip_en = 1'b0;
    tick(1);
    idle(4);
    exp_wr++;
    chk("R1 enable-close flags", 32'(viol), 0);
    check_counts("R1 enable-close");

    // R1: no lane enabled, and chip disabled: no write
    write_on(19'h502, 32'h8);
    lane_en_n = '1;
    tick(5);
    idle(3);
    write_on(19'h503, 32'h9);
    chip_en = 1'b0;
    tick(5);
    idle(4);
    chk("R1 no-write flags", 32'(viol), 0);
    check_counts("R1 no-write");

    // R7: read duration sweep
    for (int h = 1; h <= 8; h++) begin
      read_on(19'h600 + 19'(h));
      tick(h);
      idle(4);
      if (h >= T_ACC) exp_rd++;
      check_counts($sformatf("R7 read len=%0d", h));
    end

    // R7: address change restarts the access window
    read_on(19'h700);
    tick(4);
    bus_addr = 19'h701;
    tick(4);
    idle(3);
    check_counts("R7 restart short");
    read_on(19'h700);
    tick(4);
    lane_en_n = 4'b1110;
    tick(T_ACC);
    idle(4);
    exp_rd++;
    check_counts("R7 restart then full");
    chk("R7 reads leave flags clear", 32'(viol), 0);

    // R8: controller drives during a read
    clear_flags();
    read_on(19'h800);
    tick(2);
    bus_drive = 1'b1;
    tick(1);
    idle(4);
    chk("R8 contention flags", 32'(viol), 32'h10);

    // R11: flag stays until clear
    idle(6);
    chk("R11 sticky", 32'(viol), 32'h10);
    clear_flags();
    chk("R11 cleared", 32'(viol), 0);

    // R9: turnaround sweep after output enable rises
    for (int k = 1; k <= 4; k++) begin
      clear_flags();
      read_on(19'h900);
      tick(2);
      out_en_n = 1'b1;
      tick(k - 1);
      bus_drive = 1'b1;
      tick(1);
      idle(4);
      chk($sformatf("R9 turn=%0d flags", k), 32'(viol), 32'((k <= T_TURN) ? 16 : 0));
    end

    // R10: deselect right after a read, then drive
    clear_flags();
    read_on(19'hA00);
    tick(2);
    sel_n = 1'b1;
    bus_drive = 1'b1;
    tick(3);
    out_en_n = 1'b0;
    tick(2);
    chip_en = 1'b0; sel_n = 1'b0;
    tick(2);
    idle(4);
    chk("R10 deselect drive flags", 32'(viol), 0);

    // R7 with R8 in the same sample: access completes as drive starts
    clear_flags();
    read_on(19'hB00);
    tick(T_ACC - 1);
    bus_drive = 1'b1;
    tick(1);
    idle(4);
    exp_rd++;
    chk("R8 same-tick contention", 32'(viol), 32'h10);
    check_counts("R7 same-tick read");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule